// File: doc/BRIEF.md
# PLL Digital Lock Detector with Reference-Loss Drop-Out

This block decides whether a phase-locked loop is in lock. Once per phase-detector cycle it receives a strobe with a flag. The flag tells it whether that cycle's phase error fell inside the lock window. An external comparator measures the window; this block only counts its verdicts. Lock is declared after a programmable run of consecutive in-window cycles, from 1024 up to 8192. It is withdrawn at once when a cycle falls outside the window.

Other conditions also withdraw lock: the divider counters are held in reset, the synthesizer is powered down, or the reference clock stops while reference-loss detection is enabled. A free-running system-clock timeout watches the reference and flags its absence. The lock result gates two downstream enables: the RF output enable (mute until locked) and the charge-pump bleed-current enable. The window precision and delay codes pass straight through to the comparator.

The phase-detector strobe is a plain per-cycle pulse with no back-pressure. The detector accepts every strobe in the cycle it is presented and never stalls the source.

Top module: `lockdet_top`

## Requirements
- R1: With `qual_sel` code 0, 1, 2 or 3 the qualification length N is 1024, 2048, 4096 or 8192 strobes. `lock` rises on the clock edge that samples the N-th consecutive in-window strobe (`pfd_valid`=1, `win_ok`=1). After N-1 such strobes it is still low.
- R2: A strobe with `win_ok`=0 clears the run. `lock` is low from the following edge. A full new run of N in-window strobes is then needed.
- R3: Clock cycles with `pfd_valid`=0 neither advance nor break the run.
- R4: A change of `qual_sel` restarts the run from zero and clears `lock`. Strobes counted before the change do not count toward the new length.
- R5: While `cntr_hold` or `synth_off` is high, the run is cleared and `lock` is low from the next edge.
- R6: `ref_lost` rises once the reference edge input `ref_edge` has been absent for at least 4 and at most 5 full timeout periods of TICK_LEN clocks. It is low on the edge after any `ref_edge` pulse.
- R7: With `lossdet_en`=1, `ref_lost` forces `lock` low from the next edge and blocks requalification. With `lossdet_en`=0, reference loss has no effect on `lock`.
- R8: `rf_out_en` equals `rf_req` when `mute_on_unlock`=0. When `mute_on_unlock`=1 it equals `rf_req` AND `lock`.
- R9: `bleed_on` equals `bleed_req` when `gate_bleed`=0. When `gate_bleed`=1 it equals `bleed_req` AND `lock`.
- R10: `win_cfg` carries `win_fine` in bit 2 (0 = fractional 5 ns window, 1 = integer 2.4 ns window). It carries `win_bias` in bits 1:0 (0..3 = 5, 6, 8, 12 ns).
- R11: After reset `lock` and `ref_lost` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pfd_valid | input | 1 | One-cycle strobe per phase-detector cycle |
| win_ok | input | 1 | Phase error of this strobe inside the lock window |
| ref_edge | input | 1 | One-cycle pulse per reference edge, already synchronized |
| qual_sel | input | 2 | Qualification length code |
| lossdet_en | input | 1 | Enables reference-loss drop-out of lock |
| cntr_hold | input | 1 | Divider counters held in reset |
| synth_off | input | 1 | Synthesizer powered down |
| mute_on_unlock | input | 1 | Gate RF output with lock |
| rf_req | input | 1 | Requested RF output enable |
| bleed_req | input | 1 | Requested bleed-current enable |
| gate_bleed | input | 1 | Gate bleed current with lock |
| win_fine | input | 1 | Window precision select |
| win_bias | input | 2 | Window delay code |
| lock | output | 1 | Lock indication |
| ref_lost | output | 1 | Reference absent |
| rf_out_en | output | 1 | Gated RF output enable |
| bleed_on | output | 1 | Gated bleed-current enable |
| win_cfg | output | 3 | Window configuration to the comparator |

## Verification
For every length code the bench stops one strobe short and checks that lock is still low. It then adds the final strobe and checks that lock rises. An off-by-one counter would show lock one strobe early or late. The bench changes the length code after part of a run. A design that kept the old count would lock before the new length is reached. It also inserts idle cycles into a run: a design that counted clocks instead of strobes would lock early, and one that treated gaps as misses would never lock. For reference loss it checks that `ref_lost` is still low three timeout periods after the edges stop and high after six. It confirms that lock drops and cannot requalify with detection enabled, and that lock survives with detection disabled. A timeout that was too short, or a drop-out that ignored its enable, would fail these checks.

// File: rtl/lockdet_pkg.sv
package lockdet_pkg;
  typedef struct packed {
    logic       fine;
    logic [1:0] bias;
  } win_cfg_t;

  localparam int unsigned QUAL_CODES = 4;
endpackage

// File: rtl/lockdet_refmon.sv
module lockdet_refmon #(
  parameter int unsigned TICK_LEN   = 16,
  parameter int unsigned MISS_LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_edge,
  output logic ref_lost
);
  localparam int unsigned TW = (TICK_LEN > 2) ? $clog2(TICK_LEN) : 1;
  localparam int unsigned MW = $clog2(MISS_LIMIT + 1);

  logic [TW-1:0] tick_cnt;
  logic          tick;
  logic          seen;
  logic [MW-1:0] miss;

  assign tick = (tick_cnt == TW'(TICK_LEN - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick_cnt <= '0;
    else if (tick) tick_cnt <= '0;
    else tick_cnt <= tick_cnt + 1'b1;
  end

  // A period with an edge resets the miss run; an empty period extends it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen <= 1'b0;
      miss <= '0;
    end else if (ref_edge) begin
      seen <= 1'b1;
      miss <= '0;
    end else if (tick) begin
      seen <= 1'b0;
      if (seen) miss <= '0;
      else if (miss != MW'(MISS_LIMIT)) miss <= miss + 1'b1;
    end
  end

  assign ref_lost = (miss == MW'(MISS_LIMIT));
endmodule

// File: rtl/lockdet_qual.sv
module lockdet_qual #(
  parameter int unsigned BASE_LOG2 = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pfd_valid,
  input  logic       win_ok,
  input  logic [1:0] qual_sel,
  input  logic       clear,
  output logic       lock
);
  localparam int unsigned CNT_W = BASE_LOG2 + lockdet_pkg::QUAL_CODES;

  logic [CNT_W-1:0] run_cnt;
  logic [CNT_W-1:0] last_idx;
  logic [1:0]       sel_q;
  logic             sel_chg;

  assign last_idx = (CNT_W'(1) << (BASE_LOG2 + int'(qual_sel))) - CNT_W'(1);
  assign sel_chg  = (qual_sel != sel_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= 2'd1;
    else sel_q <= qual_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= '0;
      lock    <= 1'b0;
    end else if (clear || sel_chg) begin
      run_cnt <= '0;
      lock    <= 1'b0;
    end else if (pfd_valid) begin
      if (!win_ok) begin
        run_cnt <= '0;
        lock    <= 1'b0;
      end else if (run_cnt >= last_idx) begin
        lock <= 1'b1;
      end else begin
        run_cnt <= run_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/lockdet_gate.sv
module lockdet_gate (
  input  logic lock,
  input  logic mute_on_unlock,
  input  logic rf_req,
  input  logic gate_bleed,
  input  logic bleed_req,
  output logic rf_out_en,
  output logic bleed_on
);
  always_comb begin
    rf_out_en = rf_req & (lock | ~mute_on_unlock);
    bleed_on  = bleed_req & (lock | ~gate_bleed);
  end
endmodule

// File: rtl/lockdet_top.sv
module lockdet_top #(
  parameter int unsigned BASE_LOG2 = 10,
  parameter int unsigned TICK_LEN  = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pfd_valid,
  input  logic       win_ok,
  input  logic       ref_edge,
  input  logic [1:0] qual_sel,
  input  logic       lossdet_en,
  input  logic       cntr_hold,
  input  logic       synth_off,
  input  logic       mute_on_unlock,
  input  logic       rf_req,
  input  logic       bleed_req,
  input  logic       gate_bleed,
  input  logic       win_fine,
  input  logic [1:0] win_bias,
  output logic       lock,
  output logic       ref_lost,
  output logic       rf_out_en,
  output logic       bleed_on,
  output logic [2:0] win_cfg
);
  lockdet_pkg::win_cfg_t cfg;
  logic                  clear;

  lockdet_refmon #(.TICK_LEN(TICK_LEN), .MISS_LIMIT(4)) u_refmon (
    .clk(clk), .rst_n(rst_n), .ref_edge(ref_edge), .ref_lost(ref_lost)
  );

  assign clear = cntr_hold | synth_off | (lossdet_en & ref_lost);

  lockdet_qual #(.BASE_LOG2(BASE_LOG2)) u_qual (
    .clk(clk), .rst_n(rst_n), .pfd_valid(pfd_valid), .win_ok(win_ok),
    .qual_sel(qual_sel), .clear(clear), .lock(lock)
  );

  lockdet_gate u_gate (
    .lock(lock), .mute_on_unlock(mute_on_unlock), .rf_req(rf_req),
    .gate_bleed(gate_bleed), .bleed_req(bleed_req),
    .rf_out_en(rf_out_en), .bleed_on(bleed_on)
  );

  assign cfg.fine = win_fine;
  assign cfg.bias = win_bias;
  assign win_cfg  = cfg;
endmodule

// File: rtl/lockdet_sva.sv
module lockdet_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       pfd_valid,
  input logic       win_ok,
  input logic       ref_edge,
  input logic [1:0] qual_sel,
  input logic       lossdet_en,
  input logic       cntr_hold,
  input logic       synth_off,
  input logic       mute_on_unlock,
  input logic       gate_bleed,
  input logic       lock,
  input logic       ref_lost,
  input logic       rf_out_en,
  input logic       bleed_on
);
  AST_RISE_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n) $rose(lock) |-> $past(pfd_valid && win_ok)); // R1
  AST_MISS_DROPS: assert property (@(posedge clk) disable iff (!rst_n) (pfd_valid && !win_ok) |=> !lock); // R2
  AST_SEL_RESTART: assert property (@(posedge clk) disable iff (!rst_n) (qual_sel != $past(qual_sel)) |=> !lock); // R4
  AST_HOLD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (cntr_hold || synth_off) |=> !lock); // R5
  AST_EDGE_RECOVERS: assert property (@(posedge clk) disable iff (!rst_n) ref_edge |=> !ref_lost); // R6
  AST_LOSS_DROPS: assert property (@(posedge clk) disable iff (!rst_n) (lossdet_en && ref_lost) |=> !lock); // R7
  AST_RF_MUTED: assert property (@(posedge clk) disable iff (!rst_n) (mute_on_unlock && !lock) |-> !rf_out_en); // R8
  AST_BLEED_GATED: assert property (@(posedge clk) disable iff (!rst_n) (gate_bleed && !lock) |-> !bleed_on); // R9
endmodule

bind lockdet_top lockdet_sva u_sva (
  .clk(clk), .rst_n(rst_n), .pfd_valid(pfd_valid), .win_ok(win_ok),
  .ref_edge(ref_edge), .qual_sel(qual_sel), .lossdet_en(lossdet_en),
  .cntr_hold(cntr_hold), .synth_off(synth_off),
  .mute_on_unlock(mute_on_unlock), .gate_bleed(gate_bleed), .lock(lock),
  .ref_lost(ref_lost), .rf_out_en(rf_out_en), .bleed_on(bleed_on)
);

// File: tb/lockdet_top_bench.sv
module lockdet_top_bench;
  localparam int TICK = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pfd_valid = 1'b0, win_ok = 1'b0, ref_edge = 1'b0;
  logic [1:0] qual_sel = 2'd0;
  logic lossdet_en = 1'b1, cntr_hold = 1'b0, synth_off = 1'b0;
  logic mute_on_unlock = 1'b0, rf_req = 1'b1, bleed_req = 1'b0, gate_bleed = 1'b0;
  logic win_fine = 1'b0;
  logic [1:0] win_bias = 2'd3;
  logic lock, ref_lost, rf_out_en, bleed_on;
  logic [2:0] win_cfg;
  logic ref_run = 1'b1;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  lockdet_top u_lockdet_top (
    .clk(clk), .rst_n(rst_n), .pfd_valid(pfd_valid), .win_ok(win_ok),
    .ref_edge(ref_edge), .qual_sel(qual_sel), .lossdet_en(lossdet_en),
    .cntr_hold(cntr_hold), .synth_off(synth_off),
    .mute_on_unlock(mute_on_unlock), .rf_req(rf_req), .bleed_req(bleed_req),
    .gate_bleed(gate_bleed), .win_fine(win_fine), .win_bias(win_bias),
    .lock(lock), .ref_lost(ref_lost), .rf_out_en(rf_out_en),
    .bleed_on(bleed_on), .win_cfg(win_cfg)
  );

  initial begin
    int k = 0;
    forever begin
      @(negedge clk);
      k++;
      ref_edge = ref_run && (k % 8 == 0);
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run(input int n, input logic ok);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pfd_valid = 1'b1;
      win_ok = ok;
    end
    @(negedge clk);
    pfd_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R11 lock after reset", lock, 0);
    chk("R11 ref_lost after reset", ref_lost, 0);
  endtask

  task automatic t_lengths;
    for (int c = 0; c < 4; c++) begin
      qual_sel = 2'(c);
      idle(2);
      run((1024 << c) - 1, 1'b1);
      chk($sformatf("R1 code %0d short by one", c), lock, 0);
      run(1, 1'b1);
      chk($sformatf("R1 code %0d full run", c), lock, 1);
      run(1, 1'b0);
    end
    qual_sel = 2'd0;
    idle(2);
  endtask

  task automatic t_miss;
    run(1024, 1'b1);
    chk("R2 locked before miss", lock, 1);
    run(1, 1'b0);
    chk("R2 miss drops lock", lock, 0);
    run(1023, 1'b1);
    chk("R2 requalify short", lock, 0);
    run(1, 1'b1);
    chk("R2 requalify full", lock, 1);
    run(1, 1'b0);
  endtask

  task automatic t_gaps;
    run(500, 1'b1);
    idle(700);
    run(523, 1'b1);
    chk("R3 gaps not counted", lock, 0);
    idle(5);
    run(1, 1'b1);
    chk("R3 gaps not breaking", lock, 1);
    run(1, 1'b0);
  endtask

  task automatic t_selchg;
    run(600, 1'b1);
    qual_sel = 2'd1;
    idle(2);
    run(2047, 1'b1);
    chk("R4 restart after code change", lock, 0);
    run(1, 1'b1);
    chk("R4 new length reached", lock, 1);
    qual_sel = 2'd0;
    idle(2);
    chk("R4 code change clears lock", lock, 0);
  endtask

  task automatic t_hold;
    run(1024, 1'b1);
    cntr_hold = 1'b1;
    idle(1);
    cntr_hold = 1'b0;
    chk("R5 counter hold clears lock", lock, 0);
    run(1024, 1'b1);
    synth_off = 1'b1;
    idle(1);
    synth_off = 1'b0;
    chk("R5 power down clears lock", lock, 0);
  endtask

  task automatic t_loss;
    lossdet_en = 1'b1;
    run(1024, 1'b1);
    ref_run = 1'b0;
    idle(3 * TICK);
    chk("R6 not lost after 3 periods", ref_lost, 0);
    chk("R7 lock kept before loss", lock, 1);
    idle(3 * TICK + 4);
    chk("R6 lost after 6 periods", ref_lost, 1);
    chk("R7 loss drops lock", lock, 0);
    run(1024, 1'b1);
    chk("R7 no requalify while lost", lock, 0);
    ref_run = 1'b1;
    idle(10);
    chk("R6 edge clears loss", ref_lost, 0);
    run(1024, 1'b1);
    lossdet_en = 1'b0;
    ref_run = 1'b0;
    idle(6 * TICK + 4);
    chk("R6 lost with detection off", ref_lost, 1);
    chk("R7 lock kept with detection off", lock, 1);
    ref_run = 1'b1;
    lossdet_en = 1'b1;
    idle(10);
    run(1, 1'b0);
  endtask

  task automatic t_gates;
    mute_on_unlock = 1'b1; rf_req = 1'b1;
    idle(1);
    chk("R8 muted while unlocked", rf_out_en, 0);
    run(1024, 1'b1);
    chk("R8 enabled when locked", rf_out_en, 1);
    rf_req = 1'b0;
    idle(1);
    chk("R8 request low", rf_out_en, 0);
    rf_req = 1'b1; mute_on_unlock = 1'b0;
    run(1, 1'b0);
    chk("R8 no mute while unlocked", rf_out_en, 1);
    bleed_req = 1'b1; gate_bleed = 1'b1;
    idle(1);
    chk("R9 bleed gated while unlocked", bleed_on, 0);
    run(1024, 1'b1);
    chk("R9 bleed on when locked", bleed_on, 1);
    gate_bleed = 1'b0;
    run(1, 1'b0);
    chk("R9 ungated bleed while unlocked", bleed_on, 1);
    bleed_req = 1'b0;
    idle(1);
    chk("R9 bleed request low", bleed_on, 0);
  endtask

  task automatic t_wincfg;
    for (int v = 0; v < 8; v += 3) begin
      win_fine = v[2];
      win_bias = v[1:0];
      idle(1);
      chk("R10 window config", win_cfg, v);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_lengths();
    t_miss();
    t_gaps();
    t_selchg();
    t_hold();
    t_loss();
    t_gates();
    t_wincfg();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule